// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block scans a passive multiplexed LCD panel. From a flat bank of display bits it works out, every clock, which drive level each common and segment pin should present. The result is a small integer per pin, and an external ladder or switch network turns that integer into a voltage. Configuration comes in as plain register inputs: the display enable, the panel mode, the frame rate and the blink rate.

Two panel modes are supported. The narrow mode scans four commons against twenty segment pins using four voltage levels. The wide mode scans eight commons against sixteen segments using five levels, and in this mode the first four segment pins are reused as commons four to seven. Drive polarity flips on every frame, so each pixel sees zero average voltage. When the display is disabled, blinked off or held in reset, every pin rests at level 0, so no pixel carries a voltage.

Top module: `lcd_mux_seq`

## Requirements
- R1: While reset is asserted, every common and segment output is level 0, and the scan restarts at common 0 in an even frame.
- R2: Each output is a 3-bit level code. Code 0 is the top rail. The bottom rail is code 3 in four-common mode and code 4 in eight-common mode, and no output ever exceeds the bottom rail code of the current mode.
- R3: In four-common mode, commons 0 to 3 are selected one after another, each for FRAME_CYCLES/4 clocks at the slow frame rate. In an even frame the selected common drives 0 and the others drive 2. In an odd frame the selected common drives 3 and the others drive 1.
- R4: In four-common mode, segment pin s reads byte s of seg_bits (bits s*8+7 down to s*8). While common k is selected it uses bit k of that byte: a 1 drives 3 in an even frame and 0 in an odd frame, and a 0 drives 1 in an even frame and 2 in an odd frame. Bits 4 to 7 of each byte have no effect in this mode.
- R5: In eight-common mode, segment pins 0 to 3 act as commons 4 to 7. Each of the eight commons is selected for FRAME_CYCLES/8 clocks at the slow rate. The selected common drives 0 in an even frame and 4 in an odd frame, and unselected commons drive 3 in an even frame and 1 in an odd frame.
- R6: In eight-common mode, segment pins 4 to 19 use bit k of their own byte while common k is selected. A 1 drives 4 in an even frame and 0 in an odd frame, and a 0 drives 2 in both frames.
- R7: Polarity starts even after reset and toggles each time the last common of the current mode finishes its slot.
- R8: With fast_frame high, every slot is half as long, which doubles the frame rate.
- R9: One clock after disp_en is sampled low, all outputs are level 0. Normal scanning output returns once disp_en is high again.
- R10: blink_sel 0 disables blinking. For blink_sel values 1, 2 and 3, the display is visible for BLINK_BASE, 2*BLINK_BASE or 4*BLINK_BASE clocks and then held at level 0 for the same number of clocks, repeating. The first visible phase starts when blinking is enabled or reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_en | input | 1 | Display enable |
| mode8 | input | 1 | 0: four commons, 1/3 bias; 1: eight commons, 1/4 bias |
| fast_frame | input | 1 | 0: slow frame rate; 1: double frame rate |
| blink_sel | input | 2 | Blink rate select, 0 is off |
| seg_bits | input | 160 | Display bits, one byte per segment pin |
| com_lvl | output | 12 | Level codes of commons 0 to 3, 3 bits each |
| seg_lvl | output | 60 | Level codes of segment pins 0 to 19, 3 bits each |

## Verification
On every cycle the assertions check several structural rules. Level codes must stay inside the current mode's range. A display that is not blank must select exactly one common at an extreme level. Reset and a disabled display must give all-zero outputs. The exact level on each pin, the link between a display bit and the common it pairs with, the alternation of polarity from frame to frame, the slot lengths for each rate and the blink timing all depend on where the scan is. Only the bench's timed scenarios can show these, since it samples in the middle of chosen slots and phases.

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq #(
  parameter int FRAME_CYCLES = 64,
  parameter int BLINK_BASE   = 512,
  parameter int NSEG         = 20,
  parameter int LW           = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 disp_en,
  input  logic                 mode8,
  input  logic                 fast_frame,
  input  logic [1:0]           blink_sel,
  input  logic [NSEG*8-1:0]    seg_bits,
  output logic [4*LW-1:0]      com_lvl,
  output logic [NSEG*LW-1:0]   seg_lvl
);

  localparam int SLOT4 = FRAME_CYCLES / 4;
  localparam int SLOT8 = FRAME_CYCLES / 8;
  localparam int CW    = $clog2(SLOT4) + 1;
  localparam int BW    = $clog2(BLINK_BASE * 4 + 1);

  logic [CW-1:0] cnt, slot_len;
  logic [2:0]    com_idx;
  logic          pol;
  logic          slot_end, last_com;
  logic [BW-1:0] bcnt, bhalf;
  logic          bph, blank;

  assign slot_len = mode8 ? (fast_frame ? CW'(SLOT8 / 2) : CW'(SLOT8))
                          : (fast_frame ? CW'(SLOT8)     : CW'(SLOT4));
  assign slot_end = (cnt + 1'b1) >= slot_len;
  assign last_com = mode8 ? (com_idx >= 3'd7) : (com_idx >= 3'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      com_idx <= '0;
      pol     <= 1'b0;
    end else if (slot_end) begin
      cnt <= '0;
      if (last_com) begin
        com_idx <= '0;
        pol     <= ~pol;
      end else begin
        com_idx <= com_idx + 3'd1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    case (blink_sel)
      2'd1:    bhalf = BW'(BLINK_BASE);
      2'd2:    bhalf = BW'(BLINK_BASE * 2);
      default: bhalf = BW'(BLINK_BASE * 4);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || blink_sel == 2'd0) begin
      bcnt <= '0;
      bph  <= 1'b0;
    end else if ((bcnt + 1'b1) >= bhalf) begin
      bcnt <= '0;
      bph  <= ~bph;
    end else begin
      bcnt <= bcnt + 1'b1;
    end
  end

  assign blank = ~disp_en | bph;

  logic [LW-1:0] sel_l, uns_l, on_l, off_l;
  assign sel_l = pol ? (mode8 ? LW'(4) : LW'(3)) : LW'(0);
  assign uns_l = pol ? LW'(1) : (mode8 ? LW'(3) : LW'(2));
  assign on_l  = pol ? LW'(0) : (mode8 ? LW'(4) : LW'(3));
  assign off_l = mode8 ? LW'(2) : (pol ? LW'(2) : LW'(1));

  logic [4*LW-1:0]    com_nxt;
  logic [NSEG*LW-1:0] seg_nxt;
  logic [2:0]         bit_idx;

  assign bit_idx = mode8 ? com_idx : {1'b0, com_idx[1:0]};

  for (genvar c = 0; c < 4; c++) begin : g_com
    assign com_nxt[c*LW +: LW] = blank ? '0 : ((com_idx == 3'(c)) ? sel_l : uns_l);
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [7:0]    sbyte;
    logic [LW-1:0] data_l;
    assign sbyte  = seg_bits[s*8 +: 8];
    assign data_l = sbyte[bit_idx] ? on_l : off_l;
    if (s < 4) begin : g_shared
      logic [LW-1:0] as_com;
      assign as_com = (com_idx == 3'(s + 4)) ? sel_l : uns_l;
      assign seg_nxt[s*LW +: LW] = blank ? '0 : (mode8 ? as_com : data_l);
    end else begin : g_plain
      assign seg_nxt[s*LW +: LW] = blank ? '0 : data_l;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      com_lvl <= '0;
      seg_lvl <= '0;
    end else begin
      com_lvl <= com_nxt;
      seg_lvl <= seg_nxt;
    end
  end

endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
  parameter int NSEG = 20,
  parameter int LW   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               disp_en,
  input logic               mode8,
  input logic [4*LW-1:0]    com_lvl,
  input logic [NSEG*LW-1:0] seg_lvl
);
  localparam int NPIN = NSEG + 4;

  logic [NPIN*LW-1:0] all_lvl;
  logic [NPIN-1:0]    hi3, hi4;
  logic [3:0]         ext4;
  logic [7:0]         ext8;

  assign all_lvl = {seg_lvl, com_lvl};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    assign hi3[p] = all_lvl[p*LW +: LW] > LW'(3);
    assign hi4[p] = all_lvl[p*LW +: LW] > LW'(4);
  end
  for (genvar c = 0; c < 8; c++) begin : g_ext
    if (c < 4) begin : g_e4
      assign ext4[c] = (all_lvl[c*LW +: LW] == LW'(0)) || (all_lvl[c*LW +: LW] == LW'(3));
    end
    assign ext8[c] = (all_lvl[c*LW +: LW] == LW'(0)) || (all_lvl[c*LW +: LW] == LW'(4));
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (com_lvl == '0 && seg_lvl == '0));

  // R9
  blank_off_chk: assert property (@(posedge clk) disable iff (rst)
    !disp_en |=> (com_lvl == '0 && seg_lvl == '0));

  // R2
  range_all_chk: assert property (@(posedge clk) disable iff (rst)
    hi4 == '0);

  // R2
  range_third_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(mode8) |-> hi3 == '0);

  // R3
  one_sel4_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(mode8) && com_lvl != '0) |-> $countones(ext4) == 1);

  // R5
  one_sel8_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode8) && com_lvl != '0) |-> $countones(ext8) == 1);

endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(.NSEG(NSEG), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .disp_en(disp_en), .mode8(mode8),
  .com_lvl(com_lvl), .seg_lvl(seg_lvl)
);

// File: tb/sim_lcd_mux_seq.sv
module sim_lcd_mux_seq;
  localparam int FRAME = 64;
  localparam int BB    = 512;
  localparam int NSEG  = 20;
  localparam int LW    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disp_en = 1'b1, mode8 = 1'b0, fast_frame = 1'b0;
  logic [1:0] blink_sel = 2'd0;
  logic [NSEG*8-1:0] seg_bits;
  logic [4*LW-1:0] com_lvl;
  logic [NSEG*LW-1:0] seg_lvl;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lcd_mux_seq #(.FRAME_CYCLES(FRAME), .BLINK_BASE(BB)) u0 (
    .clk(clk), .rst(rst), .disp_en(disp_en), .mode8(mode8), .fast_frame(fast_frame),
    .blink_sel(blink_sel), .seg_bits(seg_bits), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // {mode8, fast, slot[3:0], sel, unsel, on, off}
  localparam logic [17:0] VEC [10] = '{
    {1'b0, 1'b0, 4'd0,  3'd0, 3'd2, 3'd3, 3'd1},
    {1'b0, 1'b0, 4'd2,  3'd0, 3'd2, 3'd3, 3'd1},
    {1'b0, 1'b0, 4'd5,  3'd3, 3'd1, 3'd0, 3'd2},  // R7 odd frame
    {1'b0, 1'b1, 4'd3,  3'd0, 3'd2, 3'd3, 3'd1},  // R8 fast rate
    {1'b0, 1'b1, 4'd7,  3'd3, 3'd1, 3'd0, 3'd2},  // R8 R7
    {1'b1, 1'b0, 4'd1,  3'd0, 3'd3, 3'd4, 3'd2},
    {1'b1, 1'b0, 4'd6,  3'd0, 3'd3, 3'd4, 3'd2},
    {1'b1, 1'b0, 4'd12, 3'd4, 3'd1, 3'd0, 3'd2},  // R7 odd frame
    {1'b1, 1'b1, 4'd9,  3'd4, 3'd1, 3'd0, 3'd2},  // R8
    {1'b1, 1'b1, 4'd15, 3'd4, 3'd1, 3'd0, 3'd2}   // R8
  };

  function automatic bit pat(int s, int k);
    return ((s * 3 + k) % 5) < 2;
  endfunction

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic restart(bit m8, bit fast, logic [1:0] bsel);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    mode8 = m8; fast_frame = fast; blink_sel = bsel; disp_en = 1'b1;
    rst = 1'b0;
  endtask

  task automatic wait_edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int s = 0; s < NSEG; s++)
      for (int k = 0; k < 8; k++)
        seg_bits[s*8 + k] = pat(s, k);

    // R1 reset state
    repeat (4) @(negedge clk);
    check("R1", "coms in reset", int'(com_lvl), 0);
    check("R1", "segs in reset", (seg_lvl == '0) ? 0 : 1, 0);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 10; v++) begin
      bit m8, fast;
      int slot, ncom, len, cidx, e;
      int l_sel, l_uns, l_on, l_off;
      {m8, fast} = VEC[v][17:16];
      slot  = int'(VEC[v][15:12]);
      l_sel = int'(VEC[v][11:9]);
      l_uns = int'(VEC[v][8:6]);
      l_on  = int'(VEC[v][5:3]);
      l_off = int'(VEC[v][2:0]);
      ncom = m8 ? 8 : 4;
      len  = (FRAME / ncom) / (fast ? 2 : 1);
      cidx = slot % ncom;
      restart(m8, fast, 2'd0);
      wait_edges(slot * len + len / 2);
      for (int c = 0; c < 4; c++) begin
        e = (c == cidx) ? l_sel : l_uns;
        check(m8 ? "R5" : "R3", $sformatf("vec %0d com %0d", v, c),
              int'(com_lvl[c*LW +: LW]), e);
      end
      for (int s = 0; s < NSEG; s++) begin
        if (m8 && s < 4) begin
          e = (s + 4 == cidx) ? l_sel : l_uns;
          check("R5", $sformatf("vec %0d shared pin %0d", v, s), int'(seg_lvl[s*LW +: LW]), e);
        end else begin
          e = pat(s, cidx) ? l_on : l_off;
          check(m8 ? "R6" : "R4", $sformatf("vec %0d seg %0d", v, s),
                int'(seg_lvl[s*LW +: LW]), e);
        end
      end
    end

    // R9 display disable and recovery
    restart(1'b0, 1'b0, 2'd0);
    wait_edges(5);
    disp_en = 1'b0;
    wait_edges(2);
    check("R9", "coms disabled", int'(com_lvl), 0);
    check("R9", "segs disabled", (seg_lvl == '0) ? 0 : 1, 0);
    disp_en = 1'b1;
    wait_edges(2);
    check("R9", "coms active again", (com_lvl != '0) ? 1 : 0, 1);

    // R10 blink rate 1
    restart(1'b0, 1'b0, 2'd1);
    wait_edges(BB / 2);
    check("R10", "sel1 visible", (com_lvl != '0) ? 1 : 0, 1);
    wait_edges(BB);
    check("R10", "sel1 blank", (com_lvl == '0 && seg_lvl == '0) ? 1 : 0, 1);
    wait_edges(BB);
    check("R10", "sel1 visible again", (com_lvl != '0) ? 1 : 0, 1);

    // R10 blink rate 2
    restart(1'b0, 1'b0, 2'd2);
    wait_edges(BB * 3 / 2);
    check("R10", "sel2 visible", (com_lvl != '0) ? 1 : 0, 1);
    wait_edges(BB);
    check("R10", "sel2 blank", (com_lvl == '0 && seg_lvl == '0) ? 1 : 0, 1);

    // R10 blink rate 3
    restart(1'b0, 1'b0, 2'd3);
    wait_edges(BB * 3);
    check("R10", "sel3 visible", (com_lvl != '0) ? 1 : 0, 1);
    wait_edges(BB * 2);
    check("R10", "sel3 blank", (com_lvl == '0 && seg_lvl == '0) ? 1 : 0, 1);

    // R1 re-entry into reset
    rst = 1'b1;
    wait_edges(1);
    check("R1", "coms after reset edge", int'(com_lvl), 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule